// File: doc/BRIEF.md
# Prefetch Usefulness Profiling Tracker

This block sits beside one slice of a distributed shared cache and keeps one extra state bit per cache line: the bit is set when the line arrived through a prefetch fill and has not been used since. The slice reports fills, evictions and demand lookups by set and way. The tracker uses these reports to classify each demand access and to count how prefetches turn out. Only the prefetcher of the local tile can fill this slice, so a single bit per line is enough to attribute every marked line to that one prefetcher.

Each demand lookup produces a registered notification with the access address, the requesting core and a two-bit outcome. The notifications can be sent to every tile's prefetcher, so each of them holds the same view of the access stream. Five saturating counters record prefetch fills, useful prefetches, prefetched lines evicted unused, ordinary hits and misses. A synchronous clear input resets all five counters without changing the line marks. The cache data array and the replacement policy are outside this block. SETS and WAYS must be powers of two.

Top module: `pfu_usefulness_tracker`

## Requirements
- R1: After reset all counters read zero, `note_valid` is low and no line is marked.
- R2: A fill with `fill_prefetch`=1 marks the addressed line. A fill with `fill_prefetch`=0 clears its mark.
- R3: A lookup with `look_hit`=1 on a marked line reports outcome 2'b10, increments `cnt_useful` and clears the mark, so a second hit on the same line reports 2'b01.
- R4: A lookup with `look_hit`=1 on an unmarked line reports outcome 2'b01 and increments `cnt_demand_hit`.
- R5: A lookup with `look_hit`=0 reports outcome 2'b00 and increments `cnt_miss`. It leaves every mark unchanged, including the mark at `look_set`/`look_way`.
- R6: `note_valid` is high in the cycle after a cycle with `look_valid` high, and only then. `note_addr` and `note_core` carry that lookup's address and core. The outcome is never 2'b11.
- R7: An eviction of a marked line increments `cnt_useless` and clears the mark. An eviction of an unmarked line counts nothing.
- R8: `cnt_pf_fill` increments once for each fill with `fill_prefetch`=1.
- R9: Every counter holds at its all-ones value instead of wrapping.
- R10: `cnt_clear` zeroes all counters at the next edge, even when an event arrives in the same cycle. It does not change any mark.
- R11: When events on the same line share a cycle, the lookup and the eviction see the mark as it was before the edge, and the fill's write decides the new mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_clear | input | 1 | Synchronous clear of all counters |
| fill_valid | input | 1 | A line is being filled |
| fill_set | input | SET_W | Set of the filled line |
| fill_way | input | WAY_W | Way of the filled line |
| fill_prefetch | input | 1 | Fill came from the local prefetcher |
| evict_valid | input | 1 | A line is being evicted |
| evict_set | input | SET_W | Set of the evicted line |
| evict_way | input | WAY_W | Way of the evicted line |
| look_valid | input | 1 | A demand lookup is reported |
| look_hit | input | 1 | Lookup hit |
| look_set | input | SET_W | Set of the lookup |
| look_way | input | WAY_W | Way that hit (ignored on a miss) |
| look_addr | input | ADDR_W | Line address of the lookup |
| look_core | input | CORE_W | Requesting core |
| note_valid | output | 1 | Notification valid |
| note_addr | output | ADDR_W | Notified address |
| note_core | output | CORE_W | Notified core |
| note_outcome | output | 2 | 00 miss, 01 hit, 10 useful prefetch |
| cnt_pf_fill | output | CNT_W | Prefetch fill count |
| cnt_useful | output | CNT_W | Useful prefetch count |
| cnt_useless | output | CNT_W | Prefetched lines evicted unused |
| cnt_demand_hit | output | CNT_W | Ordinary hit count |
| cnt_miss | output | CNT_W | Miss count |

## Verification
Every result takes one register stage. The notification for a lookup is visible after the first rising edge that samples it, and a counter reflects an event after that same edge. A mark written at an edge affects only lookups presented in later cycles. The bench drives each stimulus at a falling edge, lets one rising edge pass and compares outputs at the next falling edge. At that point it advances a reference model of marks and counters built from the requirements, and it probes marks through later lookups.

// File: rtl/pfu_pkg.sv
package pfu_pkg;
  typedef enum logic [1:0] {
    OUT_MISS   = 2'b00,
    OUT_HIT    = 2'b01,
    OUT_USEFUL = 2'b10
  } outcome_e;

  // Outcome of a demand lookup given the hit flag and the line mark
  function automatic outcome_e classify(input logic hit, input logic marked);
    if (!hit)        return OUT_MISS;
    else if (marked) return OUT_USEFUL;
    else             return OUT_HIT;
  endfunction
endpackage

// File: rtl/pfu_mark_array.sv
module pfu_mark_array #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_v,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic             fill_pref,
  input  logic             evict_v,
  input  logic [IDX_W-1:0] evict_idx,
  input  logic             use_v,
  input  logic [IDX_W-1:0] use_idx,
  input  logic [IDX_W-1:0] look_idx,
  output logic             look_mark,
  output logic             evict_mark
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] marks;

  assign look_mark  = marks[look_idx];
  assign evict_mark = marks[evict_idx];

  // Later writes win: the fill decides the new mark
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      marks <= '0;
    end else begin
      if (use_v)   marks[use_idx]   <= 1'b0;
      if (evict_v) marks[evict_idx] <= 1'b0;
      if (fill_v)  marks[fill_idx]  <= fill_pref;
    end
  end

  AST_FILL_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    fill_v |=> marks[$past(fill_idx)] == $past(fill_pref)); // R2
  AST_EVICT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    evict_v && !(fill_v && fill_idx == evict_idx) |=> !marks[$past(evict_idx)]); // R7
  AST_USE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    use_v && !(fill_v && fill_idx == use_idx) |=> !marks[$past(use_idx)]); // R3
endmodule

// File: rtl/pfu_sat_counter.sv
module pfu_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  function automatic logic [W-1:0] sat_step(input logic [W-1:0] v, input logic up);
    if (up && v != TOP) return v + 1'b1;
    return v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= sat_step(cnt, inc);
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && inc && cnt == TOP |=> cnt == TOP); // R9
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && !inc |=> $stable(cnt)); // R9
endmodule

// File: rtl/pfu_usefulness_tracker.sv
module pfu_usefulness_tracker #(
  parameter int SETS   = 64,
  parameter int WAYS   = 8,
  parameter int ADDR_W = 40,
  parameter int CORE_W = 4,
  parameter int CNT_W  = 16,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_clear,
  input  logic              fill_valid,
  input  logic [SET_W-1:0]  fill_set,
  input  logic [WAY_W-1:0]  fill_way,
  input  logic              fill_prefetch,
  input  logic              evict_valid,
  input  logic [SET_W-1:0]  evict_set,
  input  logic [WAY_W-1:0]  evict_way,
  input  logic              look_valid,
  input  logic              look_hit,
  input  logic [SET_W-1:0]  look_set,
  input  logic [WAY_W-1:0]  look_way,
  input  logic [ADDR_W-1:0] look_addr,
  input  logic [CORE_W-1:0] look_core,
  output logic              note_valid,
  output logic [ADDR_W-1:0] note_addr,
  output logic [CORE_W-1:0] note_core,
  output logic [1:0]        note_outcome,
  output logic [CNT_W-1:0]  cnt_pf_fill,
  output logic [CNT_W-1:0]  cnt_useful,
  output logic [CNT_W-1:0]  cnt_useless,
  output logic [CNT_W-1:0]  cnt_demand_hit,
  output logic [CNT_W-1:0]  cnt_miss
);
  import pfu_pkg::*;

  localparam int IDX_W = SET_W + WAY_W;
  localparam int NCNT  = 5;

  logic [IDX_W-1:0] fill_idx, evict_idx, look_idx;
  logic             look_mark, evict_mark;
  outcome_e         look_out;

  assign fill_idx  = {fill_set, fill_way};
  assign evict_idx = {evict_set, evict_way};
  assign look_idx  = {look_set, look_way};
  assign look_out  = classify(look_hit, look_mark);

  // Named event wires
  logic ev_pf_fill, ev_useful, ev_useless, ev_hit, ev_miss;
  assign ev_pf_fill = fill_valid && fill_prefetch;
  assign ev_useful  = look_valid && look_out == OUT_USEFUL;
  assign ev_hit     = look_valid && look_out == OUT_HIT;
  assign ev_miss    = look_valid && look_out == OUT_MISS;
  assign ev_useless = evict_valid && evict_mark;

  pfu_mark_array #(.IDX_W(IDX_W)) u_marks (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_v     (fill_valid),
    .fill_idx   (fill_idx),
    .fill_pref  (fill_prefetch),
    .evict_v    (evict_valid),
    .evict_idx  (evict_idx),
    .use_v      (ev_useful),
    .use_idx    (look_idx),
    .look_idx   (look_idx),
    .look_mark  (look_mark),
    .evict_mark (evict_mark)
  );

  logic [NCNT-1:0]  cnt_inc;
  logic [CNT_W-1:0] cnt_bus [NCNT];
  assign cnt_inc = {ev_miss, ev_hit, ev_useless, ev_useful, ev_pf_fill};

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    pfu_sat_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clear),
      .inc   (cnt_inc[g]),
      .cnt   (cnt_bus[g])
    );
  end

  assign cnt_pf_fill    = cnt_bus[0];
  assign cnt_useful     = cnt_bus[1];
  assign cnt_useless    = cnt_bus[2];
  assign cnt_demand_hit = cnt_bus[3];
  assign cnt_miss       = cnt_bus[4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      note_valid   <= 1'b0;
      note_addr    <= '0;
      note_core    <= '0;
      note_outcome <= OUT_MISS;
    end else begin
      note_valid <= look_valid;
      if (look_valid) begin
        note_addr    <= look_addr;
        note_core    <= look_core;
        note_outcome <= look_out;
      end
    end
  end

  AST_NOTE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    look_valid |=> note_valid); // R6
  AST_NOTE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !look_valid |=> !note_valid); // R6
  AST_OUTCOME_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    note_valid |-> note_outcome != 2'b11); // R6
  AST_USEFUL_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
    note_valid && note_outcome == 2'b10 && !$past(cnt_clear) |-> cnt_useful != '0); // R3
  AST_MISS_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
    note_valid && note_outcome == 2'b00 && !$past(cnt_clear) |-> cnt_miss != '0); // R5
endmodule

// File: tb/pfu_usefulness_tracker_test.sv
`timescale 1ns/1ps
module pfu_usefulness_tracker_test;
  localparam int SETS = 4, WAYS = 2, ADDR_W = 16, CORE_W = 2, CNT_W = 4;
  localparam int SET_W = 2, WAY_W = 1, LINES = 8;
  localparam int TOPV = 15;

  logic clk = 0, rst_n = 0, cnt_clear = 0;
  logic fill_valid = 0, fill_prefetch = 0, evict_valid = 0;
  logic [SET_W-1:0] fill_set = 0, evict_set = 0, look_set = 0;
  logic [WAY_W-1:0] fill_way = 0, evict_way = 0, look_way = 0;
  logic look_valid = 0, look_hit = 0;
  logic [ADDR_W-1:0] look_addr = 0;
  logic [CORE_W-1:0] look_core = 0;
  logic note_valid;
  logic [ADDR_W-1:0] note_addr;
  logic [CORE_W-1:0] note_core;
  logic [1:0] note_outcome;
  logic [CNT_W-1:0] cnt_pf_fill, cnt_useful, cnt_useless, cnt_demand_hit, cnt_miss;

  always #2.5 clk = ~clk;

  pfu_usefulness_tracker #(.SETS(SETS), .WAYS(WAYS), .ADDR_W(ADDR_W),
    .CORE_W(CORE_W), .CNT_W(CNT_W)) uut (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  bit mk [LINES];
  int e_pf, e_use, e_usl, e_hit, e_miss;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v < TOPV) ? v + 1 : v;
  endfunction

  task automatic check_counters(input string tag);
    chk(cnt_pf_fill == e_pf, {tag, "/R8"}, cnt_pf_fill, e_pf);
    chk(cnt_useful == e_use, {tag, "/R3"}, cnt_useful, e_use);
    chk(cnt_useless == e_usl, {tag, "/R7"}, cnt_useless, e_usl);
    chk(cnt_demand_hit == e_hit, {tag, "/R4"}, cnt_demand_hit, e_hit);
    chk(cnt_miss == e_miss, {tag, "/R5"}, cnt_miss, e_miss);
  endtask

  // One cycle of stimulus; expected values come from the requirement rules
  task automatic op(input bit fv, input int fl, input bit fp,
                    input bit ev, input int el,
                    input bit lv, input bit lh, input int ll,
                    input bit clr, input string tag);
    int exp_out, li_mark, ev_mark;
    logic [ADDR_W-1:0] a;
    logic [CORE_W-1:0] c;
    a = ADDR_W'($urandom);
    c = CORE_W'($urandom);
    @(negedge clk);
    fill_valid = fv; fill_set = SET_W'(fl >> 1); fill_way = WAY_W'(fl); fill_prefetch = fp;
    evict_valid = ev; evict_set = SET_W'(el >> 1); evict_way = WAY_W'(el);
    look_valid = lv; look_hit = lh; look_set = SET_W'(ll >> 1); look_way = WAY_W'(ll);
    look_addr = a; look_core = c; cnt_clear = clr;
    li_mark = mk[ll]; ev_mark = mk[el];
    exp_out = !lh ? 0 : (li_mark ? 2 : 1);
    // model: counters
    if (fv && fp) e_pf = sat(e_pf);
    if (ev && ev_mark) e_usl = sat(e_usl);
    if (lv) begin
      if (exp_out == 2) e_use = sat(e_use);
      else if (exp_out == 1) e_hit = sat(e_hit);
      else e_miss = sat(e_miss);
    end
    if (clr) begin e_pf = 0; e_use = 0; e_usl = 0; e_hit = 0; e_miss = 0; end
    // model: marks (fill written last)
    if (lv && exp_out == 2) mk[ll] = 0;
    if (ev) mk[el] = 0;
    if (fv) mk[fl] = fp;
    @(negedge clk);
    fill_valid = 0; evict_valid = 0; look_valid = 0; cnt_clear = 0;
    chk(note_valid == lv, {tag, "/R6 valid"}, note_valid, lv);
    if (lv) begin
      chk(note_outcome == 2'(exp_out),
          {tag, exp_out == 2 ? "/R3 outcome" : exp_out == 1 ? "/R4 outcome" : "/R5 outcome"},
          note_outcome, exp_out);
      chk(note_addr == a, {tag, "/R6 addr"}, note_addr, a);
      chk(note_core == c, {tag, "/R6 core"}, note_core, c);
    end
    check_counters(tag);
  endtask

  initial begin
    #(200000 * 5);
    chk(0, "watchdog", 0, 1);
    if (!done) begin
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    foreach (mk[i]) mk[i] = 0;
    e_pf = 0; e_use = 0; e_usl = 0; e_hit = 0; e_miss = 0;
    repeat (3) @(negedge clk);
    chk(note_valid == 0, "R1 note", note_valid, 0);
    check_counters("R1");
    rst_n = 1;
    // R1: every line unmarked after reset -> ordinary hits
    for (int l = 0; l < LINES; l++) op(0, 0, 0, 0, 0, 1, 1, l, 0, "R1 sweep");
    // R2/R8: prefetch-fill even lines, demand-fill odd lines
    for (int l = 0; l < LINES; l++) op(1, l, (l % 2) == 0, 0, 0, 0, 0, 0, 0, "R2 fill");
    // R5: misses leave marks alone (look_way pointed at each line)
    for (int l = 0; l < LINES; l++) op(0, 0, 0, 0, 0, 1, 0, l, 0, "R5 miss");
    // R3/R4: first hit pass, then second pass all ordinary
    for (int l = 0; l < LINES; l++) op(0, 0, 0, 0, 0, 1, 1, l, 0, "R3 first");
    for (int l = 0; l < LINES; l++) op(0, 0, 0, 0, 0, 1, 1, l, 0, "R3 second");
    // R2: demand fill over a prefetched line clears it
    op(1, 5, 1, 0, 0, 0, 0, 0, 0, "R2 pf");
    op(1, 5, 0, 0, 0, 0, 0, 0, 0, "R2 demand");
    op(0, 0, 0, 0, 0, 1, 1, 5, 0, "R2 probe");
    // R7: evict marked and unmarked lines, then probe
    for (int l = 0; l < LINES; l++) op(1, l, (l % 3) != 0, 0, 0, 0, 0, 0, 0, "R7 fill");
    for (int l = 0; l < LINES; l++) op(0, 0, 0, 1, l, 0, 0, 0, 0, "R7 evict");
    for (int l = 0; l < LINES; l++) op(0, 0, 0, 0, 0, 1, 1, l, 0, "R7 probe");
    // R11: same-line collisions
    op(1, 3, 1, 0, 0, 1, 1, 3, 0, "R11 fill+hit");
    op(0, 0, 0, 0, 0, 1, 1, 3, 0, "R11 probe1");
    op(1, 2, 1, 0, 0, 0, 0, 0, 0, "R11 setup");
    op(1, 2, 0, 1, 2, 1, 1, 2, 0, "R11 fill+evict+hit");
    op(0, 0, 0, 0, 0, 1, 1, 2, 0, "R11 probe2");
    op(1, 6, 1, 0, 0, 0, 0, 0, 0, "R11 setup2");
    op(1, 6, 1, 0, 0, 1, 1, 6, 0, "R11 refill+use");
    op(0, 0, 0, 0, 0, 1, 1, 6, 0, "R11 probe3");
    // R9: saturation of every counter
    for (int i = 0; i < 20; i++) begin
      op(1, 1, 1, 1, 1, 1, 0, 0, 0, "R9 sat a");
      op(1, 4, 1, 0, 0, 1, 1, 4, 0, "R9 sat b");
      op(1, 4, 0, 0, 0, 1, 1, 4, 0, "R9 sat c");
    end
    chk(cnt_miss == TOPV, "R9 miss top", cnt_miss, TOPV);
    chk(cnt_pf_fill == TOPV, "R9 pf top", cnt_pf_fill, TOPV);
    // R10: clear wins over concurrent events, marks survive
    op(1, 0, 1, 0, 0, 1, 0, 0, 1, "R10 clear");
    chk(cnt_pf_fill == 0 && cnt_miss == 0, "R10 zero", cnt_pf_fill + cnt_miss, 0);
    op(0, 0, 0, 0, 0, 1, 1, 0, 0, "R10 mark kept");
    op(0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 idle");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule